// File: doc/BRIEF.md
# Shared-Phase Read Calibration Sequencer

This block calibrates the read capture of a DDR memory interface whose ranks all share one resynchronization clock phase. Once it comes out of reset it walks through every candidate capture phase. At each phase it reads a known data pattern back from each chip select in turn and compares every returned word with the value it expects. A read that comes back wrong ends the phase early. A read that never comes back is also treated as a failure.

At the end of the sweep the block holds a bitmap of the phases at which every rank passed. It chooses the centre of the longest unbroken run in that bitmap, drives that phase on its phase-select output and raises a success flag. If no phase worked for all ranks, it raises a fail flag instead. A separate active-low soft reset lets the memory controller discard the result and calibrate again from the start.

Top module: `rdcal_seq`

## Requirements
- R1: Both `rst_n` and `soft_rst_n` are synchronous and active low. While either is low at a rising edge, `cal_pass`, `cal_fail`, `rd_req` and `cs_sel` go to zero. After both are high again the sweep starts without any other input, and the first request targets phase 0, rank 0.
- R2: Phases are visited in ascending order from 0 to NUM_PHASES-1. Within a phase, ranks are visited in ascending order. Each read is a one-cycle `rd_req` pulse. While the pulse is high, `cs_sel` is one-hot, with bit r selecting rank r, and `phase_sel` shows the phase under test. Both stay unchanged in the cycle after the pulse.
- R3: A rank passes at a phase only if READS_PER_PAIR consecutive reads all return the expected data. For the k-th read of the pair (k counted from 0), the expected data is 16'hA5C3 rotated left by k bits.
- R4: A read counts as a mismatch if `rd_valid` is not seen within TIMEOUT cycles after its request.
- R5: The first failing read ends the whole phase. No further reads are issued at that phase, and the sweep resumes at rank 0 of the next phase.
- R6: A phase is in the common window only if every rank passed there. The block chooses the longest contiguous run of common phases, with no wrap-around and the lowest run winning a tie. It then drives start + (length-1)/2 on `phase_sel` and sets `cal_pass`.
- R7: If no phase passes for all ranks, `cal_fail` is set and `phase_sel` reads 0.
- R8: `cal_pass` and `cal_fail` are never high together. Once set, a flag holds until the next reset or soft reset.
- R9: Pulling `soft_rst_n` low in the middle of a sweep aborts it. Releasing it runs the whole calibration again from phase 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Global reset, synchronous, active low |
| soft_rst_n | input | 1 | Recalibration reset, synchronous, active low |
| phase_sel | output | PH_W (3) | Capture phase under test, or the chosen phase once done |
| cs_sel | output | NUM_RANKS (4) | One-hot rank select while a read is outstanding |
| rd_req | output | 1 | One-cycle read request |
| rd_valid | input | 1 | Returned read data is valid this cycle |
| rd_data | input | DATA_W (16) | Returned read data |
| cal_pass | output | 1 | Calibration finished with a usable phase |
| cal_fail | output | 1 | Calibration finished with no usable phase |

## Verification
The assertions assume that the read path answers each request with at most one `rd_valid` pulse. The pulse either arrives within the timeout window or never arrives. The assertions also assume that no stray `rd_valid` arrives while no read is outstanding. The bench responder keeps to this. It answers a fixed two cycles after a request, or stays silent for a whole request, and a new request can only follow once the previous one is resolved. Resets are always driven on falling edges, so both reset inputs change well away from the sampling edge.

// File: rtl/rdcal_pkg.sv
package rdcal_pkg;

    typedef enum logic [2:0] {
        ST_START = 3'd0,
        ST_ISSUE = 3'd1,
        ST_WAIT  = 3'd2,
        ST_EVAL  = 3'd3,
        ST_DONE  = 3'd4
    } cal_state_e;

    typedef struct packed {
        logic done;
        logic ok;
    } rd_verdict_t;

    function automatic int unsigned idx_width(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/rdcal_read_check.sv
module rdcal_read_check
    import rdcal_pkg::*;
#(
    parameter int unsigned DATA_W  = 16,
    parameter int unsigned REP_W   = 2,
    parameter int unsigned TIMEOUT = 12,
    parameter logic [DATA_W-1:0] PAT_SEED = 16'hA5C3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [REP_W-1:0]  rep_idx,
    input  logic              rd_valid,
    input  logic [DATA_W-1:0] rd_data,
    output rd_verdict_t       verdict
);
    localparam int unsigned TO_W = $clog2(TIMEOUT + 1);
    localparam logic [TO_W-1:0] TO_LAST = TO_W'(TIMEOUT - 1);

    logic            busy_q;
    logic [TO_W-1:0] wait_cnt_q;
    logic [2*DATA_W-1:0] rot_full;
    logic [DATA_W-1:0]   expected;

    // the k-th read of a pair must return the seed rotated left by k
    always_comb begin
        rot_full = {PAT_SEED, PAT_SEED} << rep_idx;
        expected = rot_full[2*DATA_W-1:DATA_W];
    end

    always_comb begin
        verdict.done = busy_q && (rd_valid || wait_cnt_q == TO_LAST);
        verdict.ok   = busy_q && rd_valid && (rd_data == expected);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q     <= 1'b0;
            wait_cnt_q <= '0;
        end else if (start) begin
            busy_q     <= 1'b1;
            wait_cnt_q <= '0;
        end else if (busy_q) begin
            if (verdict.done) begin
                busy_q <= 1'b0;
            end else begin
                wait_cnt_q <= wait_cnt_q + 1'b1;
            end
        end
    end

    // R4
    wait_bound_chk: assert property (@(posedge clk) disable iff (rst)
        busy_q |-> (wait_cnt_q < TO_W'(TIMEOUT)));

    // R4
    start_arms_chk: assert property (@(posedge clk) disable iff (rst)
        start |=> busy_q);

endmodule

// File: rtl/rdcal_window_pick.sv
module rdcal_window_pick
    import rdcal_pkg::*;
#(
    parameter int unsigned NUM_PHASES = 8,
    localparam int unsigned PH_W = idx_width(NUM_PHASES)
) (
    input  logic [NUM_PHASES-1:0] pass_vec,
    output logic                  found,
    output logic [PH_W-1:0]       centre
);
    int unsigned run_len;
    int unsigned run_start;
    int unsigned best_len;
    int unsigned best_start;

    always_comb begin
        run_len    = 0;
        run_start  = 0;
        best_len   = 0;
        best_start = 0;
        for (int unsigned i = 0; i < NUM_PHASES; i++) begin
            if (pass_vec[i]) begin
                if (run_len == 0) begin
                    run_start = i;
                end
                run_len = run_len + 1;
                // strict compare keeps the lowest run on a tie
                if (run_len > best_len) begin
                    best_len   = run_len;
                    best_start = run_start;
                end
            end else begin
                run_len = 0;
            end
        end
        found  = (best_len != 0);
        centre = found ? PH_W'(best_start + (best_len - 1) / 2) : '0;
    end

endmodule

// File: rtl/rdcal_seq.sv
module rdcal_seq
    import rdcal_pkg::*;
#(
    parameter int unsigned NUM_PHASES     = 8,
    parameter int unsigned NUM_RANKS      = 4,
    parameter int unsigned DATA_W         = 16,
    parameter int unsigned READS_PER_PAIR = 4,
    parameter int unsigned TIMEOUT        = 12,
    parameter logic [DATA_W-1:0] PAT_SEED = 16'hA5C3,
    localparam int unsigned PH_W  = idx_width(NUM_PHASES),
    localparam int unsigned RK_W  = idx_width(NUM_RANKS),
    localparam int unsigned REP_W = idx_width(READS_PER_PAIR)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 soft_rst_n,
    output logic [PH_W-1:0]      phase_sel,
    output logic [NUM_RANKS-1:0] cs_sel,
    output logic                 rd_req,
    input  logic                 rd_valid,
    input  logic [DATA_W-1:0]    rd_data,
    output logic                 cal_pass,
    output logic                 cal_fail
);
    localparam logic [PH_W-1:0]  PH_LAST  = PH_W'(NUM_PHASES - 1);
    localparam logic [RK_W-1:0]  RK_LAST  = RK_W'(NUM_RANKS - 1);
    localparam logic [REP_W-1:0] REP_LAST = REP_W'(READS_PER_PAIR - 1);

    logic rst;
    cal_state_e state_q;
    logic [PH_W-1:0]       ph_q;
    logic [RK_W-1:0]       rk_q;
    logic [REP_W-1:0]      rep_q;
    logic [NUM_PHASES-1:0] pass_vec_q;
    logic [PH_W-1:0]       chosen_q;
    logic                  pass_q;
    logic                  fail_q;
    rd_verdict_t           verdict;
    logic                  pick_found;
    logic [PH_W-1:0]       pick_phase;

    assign rst = !rst_n || !soft_rst_n;

    rdcal_read_check #(
        .DATA_W   (DATA_W),
        .REP_W    (REP_W),
        .TIMEOUT  (TIMEOUT),
        .PAT_SEED (PAT_SEED)
    ) u_check (
        .clk      (clk),
        .rst      (rst),
        .start    (rd_req),
        .rep_idx  (rep_q),
        .rd_valid (rd_valid),
        .rd_data  (rd_data),
        .verdict  (verdict)
    );

    rdcal_window_pick #(
        .NUM_PHASES (NUM_PHASES)
    ) u_pick (
        .pass_vec (pass_vec_q),
        .found    (pick_found),
        .centre   (pick_phase)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_START;
            ph_q       <= '0;
            rk_q       <= '0;
            rep_q      <= '0;
            pass_vec_q <= '0;
            chosen_q   <= '0;
            pass_q     <= 1'b0;
            fail_q     <= 1'b0;
        end else begin
            case (state_q)
                ST_START: state_q <= ST_ISSUE;
                ST_ISSUE: state_q <= ST_WAIT;
                ST_WAIT: begin
                    if (verdict.done) begin
                        if (verdict.ok && rep_q != REP_LAST) begin
                            rep_q   <= rep_q + 1'b1;
                            state_q <= ST_ISSUE;
                        end else if (verdict.ok && rk_q != RK_LAST) begin
                            rep_q   <= '0;
                            rk_q    <= rk_q + 1'b1;
                            state_q <= ST_ISSUE;
                        end else begin
                            // phase resolved: all ranks passed, or one read failed
                            rep_q <= '0;
                            rk_q  <= '0;
                            if (verdict.ok) begin
                                pass_vec_q[ph_q] <= 1'b1;
                            end
                            if (ph_q == PH_LAST) begin
                                state_q <= ST_EVAL;
                            end else begin
                                ph_q    <= ph_q + 1'b1;
                                state_q <= ST_ISSUE;
                            end
                        end
                    end
                end
                ST_EVAL: begin
                    pass_q   <= pick_found;
                    fail_q   <= !pick_found;
                    chosen_q <= pick_found ? pick_phase : '0;
                    state_q  <= ST_DONE;
                end
                default: state_q <= ST_DONE;
            endcase
        end
    end

    always_comb begin
        rd_req    = (state_q == ST_ISSUE);
        phase_sel = (state_q == ST_DONE) ? chosen_q : ph_q;
        cs_sel    = '0;
        if (state_q == ST_ISSUE || state_q == ST_WAIT) begin
            cs_sel[rk_q] = 1'b1;
        end
        cal_pass = pass_q;
        cal_fail = fail_q;
    end

    // R8
    flags_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(cal_pass && cal_fail));

    // R8
    pass_hold_chk: assert property (@(posedge clk) disable iff (rst)
        cal_pass |=> cal_pass);

    // R8
    fail_hold_chk: assert property (@(posedge clk) disable iff (rst)
        cal_fail |=> cal_fail);

    // R2
    req_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        rd_req |-> ($countones(cs_sel) == 1));

    // R2
    req_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        rd_req |=> !rd_req);

    // R2
    target_hold_chk: assert property (@(posedge clk) disable iff (rst)
        rd_req |=> ($stable(phase_sel) && $stable(cs_sel)));

    // R6
    pick_valid_chk: assert property (@(posedge clk) disable iff (rst)
        cal_pass |-> pass_vec_q[phase_sel]);

    // R7
    fail_phase_chk: assert property (@(posedge clk) disable iff (rst)
        cal_fail |-> (phase_sel == '0 && pass_vec_q == '0));

    // R5
    quiet_done_chk: assert property (@(posedge clk) disable iff (rst)
        (cal_pass || cal_fail) |-> (!rd_req && cs_sel == '0));

endmodule

// File: tb/rdcal_seq_bench.sv
module rdcal_seq_bench;
    localparam int LAT = 2;

    typedef struct packed {
        logic [7:0] m0;
        logic [7:0] m1;
        logic [7:0] m2;
        logic [7:0] m3;
        logic [7:0] silent1;
        logic [3:0] glitch;
        logic       exp_pass;
        logic [2:0] exp_ph;
        logic [7:0] exp_reads;
    } vec_t;

    localparam int NVEC = 9;
    localparam vec_t VECS [NVEC] = '{
        '{8'h3C, 8'h3C, 8'h3C, 8'h3C, 8'h00, 4'hF, 1'b1, 3'd3, 8'd68},
        '{8'h3C, 8'h7E, 8'h1F, 8'hF0, 8'h00, 4'hF, 1'b1, 3'd4, 8'd55},
        '{8'h0F, 8'hF0, 8'hFF, 8'hFF, 8'h00, 4'hF, 1'b0, 3'd0, 8'd24},
        '{8'hFF, 8'hFF, 8'hE3, 8'hFF, 8'h00, 4'hF, 1'b1, 3'd6, 8'd107},
        '{8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'h07, 4'hF, 1'b1, 3'd5, 8'd95},
        '{8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'h00, 4'h4, 1'b1, 3'd1, 8'd115},
        '{8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'h00, 4'hF, 1'b1, 3'd3, 8'd128},
        '{8'h80, 8'h80, 8'h80, 8'h80, 8'h00, 4'hF, 1'b1, 3'd7, 8'd23},
        '{8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 4'hF, 1'b0, 3'd0, 8'd8}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        soft_rst_n = 1'b1;
    logic [2:0]  phase_sel;
    logic [3:0]  cs_sel;
    logic        rd_req;
    logic        rd_valid = 1'b0;
    logic [15:0] rd_data = '0;
    logic        cal_pass;
    logic        cal_fail;

    int n_chk = 0;
    int n_fail = 0;
    vec_t cfg = VECS[6];

    int reads;
    int ord_err;
    int first_err;
    int pend_cnt;
    bit pend_silent;
    logic [15:0] pend_data;
    bit have_last;
    int last_ph;
    int last_rk;
    int pair_idx;

    always #5 clk = ~clk;

    rdcal_seq u_rdcal_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .soft_rst_n (soft_rst_n),
        .phase_sel  (phase_sel),
        .cs_sel     (cs_sel),
        .rd_req     (rd_req),
        .rd_valid   (rd_valid),
        .rd_data    (rd_data),
        .cal_pass   (cal_pass),
        .cal_fail   (cal_fail)
    );

    task automatic check(input bit cond, input string req, input int act, input int exp);
        n_chk++;
        if (!cond) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // behavioural read-return model and request monitor
    always @(negedge clk) begin
        if (!rst_n || !soft_rst_n) begin
            rd_valid  = 1'b0;
            pend_cnt  = 0;
            have_last = 1'b0;
            reads     = 0;
            ord_err   = 0;
            first_err = 0;
            pair_idx  = 0;
        end else begin
            rd_valid = 1'b0;
            if (pend_cnt > 0) begin
                pend_cnt--;
                if (pend_cnt == 0 && !pend_silent) begin
                    rd_valid = 1'b1;
                    rd_data  = pend_data;
                end
            end
            if (rd_req) begin
                int rk;
                int ph;
                logic [7:0]  msk;
                logic [31:0] dbl;
                logic [15:0] good;
                rk = -1;
                for (int i = 0; i < 4; i++) if (cs_sel[i]) rk = (rk == -1) ? i : 99;
                ph = int'(phase_sel);
                if (rk < 0 || rk > 3) ord_err++;
                if (!have_last) begin
                    if (ph != 0 || rk != 0) first_err++;
                    pair_idx = 0;
                end else if (ph == last_ph && rk == last_rk) begin
                    pair_idx++;
                end else begin
                    if (ph < last_ph || (ph == last_ph && rk < last_rk)) ord_err++;
                    if (ph > last_ph && rk != 0) ord_err++;
                    pair_idx = 0;
                end
                have_last = 1'b1;
                last_ph   = ph;
                last_rk   = rk;
                reads++;
                case (rk)
                    0: msk = cfg.m0;
                    1: msk = cfg.m1;
                    2: msk = cfg.m2;
                    default: msk = cfg.m3;
                endcase
                dbl  = {16'hA5C3, 16'hA5C3} << pair_idx;
                good = dbl[31:16];
                if (!msk[ph[2:0]] ||
                    (cfg.glitch == {1'b0, ph[2:0]} && rk == 0 && pair_idx == 2))
                    good = good ^ 16'h0001;
                pend_data   = good;
                pend_silent = (rk == 1) && cfg.silent1[ph[2:0]];
                pend_cnt    = LAT;
            end
        end
    end

    task automatic wait_done();
        int cyc;
        cyc = 0;
        while (!(cal_pass || cal_fail) && cyc < 8000) begin
            @(negedge clk);
            cyc++;
        end
        check(cyc < 8000, "R2 sweep completes", cyc, 8000);
    endtask

    task automatic restart();
        @(negedge clk);
        soft_rst_n = 1'b0;
        repeat (2) @(negedge clk);
        soft_rst_n = 1'b1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog R2: actual %0d expected %0d", 1, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check(!cal_pass && !cal_fail, "R1 flags in reset", int'({cal_pass, cal_fail}), 0);
        check(!rd_req && cs_sel == 4'd0, "R1 no read in reset", int'({rd_req, cs_sel}), 0);
        rst_n = 1'b1;
        wait_done();
        check(first_err == 0, "R1 first read at phase 0 rank 0", first_err, 0);
        check(cal_pass == 1'b1, "R1 unprompted start completes", int'(cal_pass), 1);

        // table of windows walked in one loop
        for (int v = 0; v < NVEC; v++) begin
            cfg = VECS[v];
            restart();
            wait_done();
            // R6 R7 result flags
            check(cal_pass == cfg.exp_pass, "R6 pass flag", int'(cal_pass), int'(cfg.exp_pass));
            check(cal_fail == !cfg.exp_pass, "R7 fail flag", int'(cal_fail), int'(!cfg.exp_pass));
            // R6 centre of longest common run, R7 phase zero on failure
            check(phase_sel == cfg.exp_ph, "R6 chosen phase", int'(phase_sel), int'(cfg.exp_ph));
            // R3 R4 R5 read count depends on early exit and pass rule
            check(reads == int'(cfg.exp_reads), "R5 read count", reads, int'(cfg.exp_reads));
            check(ord_err == 0 && first_err == 0, "R2 sweep order", ord_err + first_err, 0);
        end

        // R8: flags hold and stay exclusive after completion
        cfg = VECS[0];
        restart();
        wait_done();
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (!(cal_pass && !cal_fail && phase_sel == 3'd3)) begin
                check(1'b0, "R8 result held", int'({cal_pass, cal_fail}), 2);
            end
        end
        check(cal_pass && !cal_fail, "R8 result held", int'({cal_pass, cal_fail}), 2);

        // R9: soft reset after completion clears flags
        soft_rst_n = 1'b0;
        @(negedge clk);
        check(!cal_pass && !cal_fail, "R9 soft reset clears flags", int'({cal_pass, cal_fail}), 0);
        check(!rd_req && cs_sel == 4'd0, "R9 soft reset idles reads", int'({rd_req, cs_sel}), 0);

        // R9: abort mid-sweep, then a full rerun
        cfg = VECS[6];
        soft_rst_n = 1'b1;
        repeat (100) @(negedge clk);
        check(reads > 0 && !cal_pass && !cal_fail, "R9 sweep in progress", reads, 1);
        soft_rst_n = 1'b0;
        @(negedge clk);
        check(!rd_req && !cal_pass && !cal_fail, "R9 abort", int'({rd_req, cal_pass, cal_fail}), 0);
        soft_rst_n = 1'b1;
        wait_done();
        check(reads == 128, "R9 rerun from phase 0", reads, 128);
        check(cal_pass && phase_sel == 3'd3, "R9 rerun result", int'(phase_sel), 3);
        check(first_err == 0, "R9 rerun first target", first_err, 0);

        // R1: global reset also returns to idle
        rst_n = 1'b0;
        @(negedge clk);
        check(!cal_pass && !cal_fail && !rd_req, "R1 global reset", int'({cal_pass, cal_fail, rd_req}), 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule